// File: doc/BRIEF.md
# Delayed Lockstep Safety Monitor

This block watches a main processor core and a shadow core that runs the same program a small number of clock cycles behind it. On every cycle it stores a fixed vector of main-core state, built from core inputs and outputs, in a short delay line. Once the programmed lag has passed, it compares the stored entry with the vector the shadow core presents on that cycle. Because the two cores see the same work at different times, a single disturbance that hits both of them at once does not produce two identical wrong results.

On the first mismatch the monitor latches a two-bit fault code and asks both cores to freeze, so their state can be inspected. It then runs one recovery action chosen when the fault is caught: a core reset request, a level interrupt, or a one-cycle message to a host that carries the position of the first differing bit. The shadow core may still read memory through the monitor, but any write it requests is dropped before it reaches memory.

Software or a supervisor holds `mon_en_i` low to reprogram the lag and raises it to start supervision. A pulse on `err_clr_i` releases a latched fault.

Top module: `lockstep_monitor`

## Requirements
- R1: After reset is released, `err_o` is 2'b01, `freeze_main_o`, `freeze_shadow_o`, `core_rst_o`, `irq_o` and `host_vld_o` are low, and `host_code_o` is zero.
- R2: With `mon_en_i` high and the lag set to L (1 or 2), a shadow stream equal to the main stream delayed by L cycles never raises a fault.
- R3: When comparison is active and `shadow_vec_i` differs from the main vector sampled L cycles earlier, `err_o` becomes 2'b10 from the next clock edge on, and both freeze outputs go high.
- R4: `err_o` holds 2'b10 until `err_clr_i` is sampled high. After that edge it reads 2'b01. A clear also empties the delay line, and a clear cycle never reports a new fault.
- R5: After the delay line has been emptied, no compare takes place until L main vectors have been captured, so the first L shadow vectors are ignored.
- R6: When the action input is 0 or 3 at the moment of detection, `core_rst_o` is high for as long as the fault is latched, and `irq_o` stays low.
- R7: When the action input is 1 at detection, `irq_o` is a level that stays high until the fault is cleared, and `core_rst_o` stays low.
- R8: When the action input is 2 at detection, `host_vld_o` is high for exactly one cycle, in the cycle after the detecting edge. `host_code_o` then carries the index of the lowest differing bit, holds it until `host_ack_i` is sampled high, and returns to zero after that edge.
- R9: `shadow_req_o` equals `shadow_req_i` when `shadow_we_i` is low, and is low whenever `shadow_we_i` is high.
- R10: The lag input is taken only while `mon_en_i` is low. A value of 0 is treated as 1, and a value above the maximum is treated as the maximum. While `mon_en_i` is low, the delay line is emptied and no fault is raised.
- R11: `err_o` only ever shows 2'b01 (no fault) or 2'b10 (fault). Internally, the values 00 and 11 also count as a fault.
- R12: The recovery action is captured when the fault is detected. Changing the action input while the fault is latched does not alter `irq_o` or `core_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Supervision enable; low means idle |
| err_clr_i | input | 1 | Clears a latched fault and empties the delay line |
| lag_cfg_i | input | LAG_W | Requested lag in cycles |
| action_cfg_i | input | 2 | Recovery action: 0/3 reset, 1 interrupt, 2 host message |
| main_vec_i | input | VEC_W | Captured main-core state vector |
| shadow_vec_i | input | VEC_W | Shadow-core state vector |
| shadow_req_i | input | 1 | Shadow-core memory request |
| shadow_we_i | input | 1 | Shadow-core write qualifier |
| host_ack_i | input | 1 | Host acknowledge of the message |
| shadow_req_o | output | 1 | Memory request passed on, writes dropped |
| err_o | output | 2 | Complementary fault code |
| freeze_main_o | output | 1 | Freeze request to the main core |
| freeze_shadow_o | output | 1 | Freeze request to the shadow core |
| core_rst_o | output | 1 | Core reset request |
| irq_o | output | 1 | Level interrupt to the core |
| host_vld_o | output | 1 | One-cycle host message valid |
| host_code_o | output | CODE_W | Lowest differing bit index |

## Verification
Two events that can land on the same edge are a lag reprogram request and a real mismatch. The bench drives a new lag value while supervision is running and, with that value still on the input, injects a shadow vector that is wrong for the old lag. It expects the fault to be reported against the old lag, with the host code of the flipped bit, which shows that the request was ignored. A clear and a would-be mismatch can also coincide; the bench drives garbage shadow data during the clear cycle and expects the fault code to return to 01 rather than stay set.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ACT_RESET     = 2'd0,
    ACT_IRQ       = 2'd1,
    ACT_HOST      = 2'd2,
    ACT_RESET_ALT = 2'd3
  } action_e;

  localparam logic [1:0] ERR_OK    = 2'b01;
  localparam logic [1:0] ERR_FAULT = 2'b10;
endpackage

// File: rtl/lsm_delay_line.sv
module lsm_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  parameter int LAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             flush_i,
  input  logic [W-1:0]     data_i,
  input  logic [LAG_W-1:0] lag_i,
  output logic [W-1:0]     tap_o,
  output logic             ready_o
);
  localparam logic [LAG_W-1:0] FILL_MAX = LAG_W'(DEPTH);

  logic [W-1:0]     stage_q [DEPTH];
  logic [LAG_W-1:0] fill_q, fill_d;

  // shift register stages, one clock enable shared by all
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic [W-1:0] stage_d;
    if (k == 0) begin : g_head
      assign stage_d = data_i;
    end else begin : g_body
      assign stage_d = stage_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[k] <= '0;
      else if (push_i) stage_q[k] <= stage_d;
    end
  end

  always_comb begin
    fill_d = fill_q;
    if (flush_i)                        fill_d = '0;
    else if (push_i && fill_q < FILL_MAX) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  always_comb begin
    tap_o = stage_q[0];
    for (int k = 0; k < DEPTH; k++)
      if (lag_i == LAG_W'(k + 1)) tap_o = stage_q[k];
  end

  assign ready_o = (fill_q >= lag_i);
endmodule

// File: rtl/lsm_compare.sv
module lsm_compare #(
  parameter int W      = 16,
  parameter int CODE_W = 4
) (
  input  logic [W-1:0]      ref_i,
  input  logic [W-1:0]      obs_i,
  output logic              diff_o,
  output logic [CODE_W-1:0] code_o
);
  logic [W-1:0] syn;
  assign syn    = ref_i ^ obs_i;
  assign diff_o = |syn;

  // index of the lowest differing bit
  always_comb begin
    code_o = '0;
    for (int i = W - 1; i >= 0; i--)
      if (syn[i]) code_o = CODE_W'(i);
  end
endmodule

// File: rtl/lsm_respond.sv
module lsm_respond
  import lsm_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        action_i,
  input  logic              clr_i,
  input  logic              host_ack_i,
  output logic              fault_o,
  output logic [1:0]        err_o,
  output logic              core_rst_o,
  output logic              irq_o,
  output logic              host_vld_o,
  output logic [CODE_W-1:0] host_code_o
);
  logic [1:0]        err_q, err_d;
  action_e           act_q, act_d;
  logic              vld_q, vld_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    err_d  = err_q;
    act_d  = act_q;
    vld_d  = 1'b0;
    code_d = code_q;
    if (clr_i)         err_d = ERR_OK;
    else if (detect_i) err_d = ERR_FAULT;
    if (detect_i) begin
      act_d = action_e'(action_i);
      if (action_e'(action_i) == ACT_HOST) begin
        vld_d  = 1'b1;
        code_d = code_i;
      end
    end else if (host_ack_i) begin
      code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= ERR_OK;
      act_q  <= ACT_RESET;
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      err_q  <= err_d;
      act_q  <= act_d;
      vld_q  <= vld_d;
      code_q <= code_d;
    end
  end

  // any code other than the healthy one counts as a fault
  assign fault_o     = (err_q != ERR_OK);
  assign err_o       = fault_o ? ERR_FAULT : ERR_OK;
  assign core_rst_o  = fault_o && (act_q == ACT_RESET || act_q == ACT_RESET_ALT);
  assign irq_o       = fault_o && (act_q == ACT_IRQ);
  assign host_vld_o  = vld_q;
  assign host_code_o = code_q;
endmodule

// File: rtl/lockstep_monitor.sv
module lockstep_monitor #(
  parameter int VEC_W   = 16,
  parameter int MAX_LAG = 2,
  localparam int LAG_W  = $clog2(MAX_LAG + 1),
  localparam int CODE_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en_i,
  input  logic              err_clr_i,
  input  logic [LAG_W-1:0]  lag_cfg_i,
  input  logic [1:0]        action_cfg_i,
  input  logic [VEC_W-1:0]  main_vec_i,
  input  logic [VEC_W-1:0]  shadow_vec_i,
  input  logic              shadow_req_i,
  input  logic              shadow_we_i,
  input  logic              host_ack_i,
  output logic              shadow_req_o,
  output logic [1:0]        err_o,
  output logic              freeze_main_o,
  output logic              freeze_shadow_o,
  output logic              core_rst_o,
  output logic              irq_o,
  output logic              host_vld_o,
  output logic [CODE_W-1:0] host_code_o
);
  localparam logic [LAG_W-1:0] LAG_TOP = LAG_W'(MAX_LAG);

  logic [LAG_W-1:0] lag_q, lag_d, lag_req;
  logic             fault, push, flush, ready, diff, detect;
  logic [VEC_W-1:0] tap;
  logic [CODE_W-1:0] code;

  // requested lag, saturated into 1..MAX_LAG
  always_comb begin
    lag_req = lag_cfg_i;
    if (lag_cfg_i == '0)         lag_req = LAG_W'(1);
    else if (lag_cfg_i > LAG_TOP) lag_req = LAG_TOP;
  end

  // lag accepted only while supervision is idle
  always_comb begin
    lag_d = lag_q;
    if (!mon_en_i) lag_d = lag_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lag_q <= LAG_W'(1);
    else        lag_q <= lag_d;
  end

  assign flush  = !mon_en_i || err_clr_i;
  assign push   = mon_en_i && !fault && !err_clr_i;
  assign detect = push && ready && diff;

  lsm_delay_line #(.W(VEC_W), .DEPTH(MAX_LAG), .LAG_W(LAG_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .flush_i (flush),
    .data_i  (main_vec_i),
    .lag_i   (lag_q),
    .tap_o   (tap),
    .ready_o (ready)
  );

  lsm_compare #(.W(VEC_W), .CODE_W(CODE_W)) u_cmp (
    .ref_i  (tap),
    .obs_i  (shadow_vec_i),
    .diff_o (diff),
    .code_o (code)
  );

  lsm_respond #(.CODE_W(CODE_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .detect_i    (detect),
    .code_i      (code),
    .action_i    (action_cfg_i),
    .clr_i       (err_clr_i),
    .host_ack_i  (host_ack_i),
    .fault_o     (fault),
    .err_o       (err_o),
    .core_rst_o  (core_rst_o),
    .irq_o       (irq_o),
    .host_vld_o  (host_vld_o),
    .host_code_o (host_code_o)
  );

  assign freeze_main_o   = fault;
  assign freeze_shadow_o = fault;
  assign shadow_req_o    = shadow_req_i && !shadow_we_i;
endmodule

// File: rtl/lockstep_monitor_chk.sv
module lockstep_monitor_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mon_en_i,
  input logic              err_clr_i,
  input logic              shadow_we_i,
  input logic              shadow_req_o,
  input logic [1:0]        err_o,
  input logic              freeze_main_o,
  input logic              freeze_shadow_o,
  input logic              core_rst_o,
  input logic              irq_o,
  input logic              host_vld_o,
  input logic [CODE_W-1:0] host_code_o
);
  a_r11_err_legal: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == 2'b01 || err_o == 2'b10);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == 2'b10 && !err_clr_i) |=> err_o == 2'b10);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> err_o == 2'b01);

  a_r3_freeze_both: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == 2'b10 |-> freeze_main_o && freeze_shadow_o);

  a_r3_quiet_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == 2'b01 |-> !freeze_main_o && !freeze_shadow_o && !irq_o && !core_rst_o);

  a_r8_host_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_vld_o |=> !host_vld_o);

  a_r8_host_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    host_vld_o |-> err_o == 2'b10);

  a_r9_write_block: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we_i |-> !shadow_req_o);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en_i && err_o == 2'b01) |=> err_o == 2'b01);

  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && core_rst_o));

  a_r12_action_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == 2'b10 && $past(err_o) == 2'b10) |-> $stable(irq_o) && $stable(core_rst_o));
endmodule

bind lockstep_monitor lockstep_monitor_chk #(.CODE_W(CODE_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mon_en_i        (mon_en_i),
  .err_clr_i       (err_clr_i),
  .shadow_we_i     (shadow_we_i),
  .shadow_req_o    (shadow_req_o),
  .err_o           (err_o),
  .freeze_main_o   (freeze_main_o),
  .freeze_shadow_o (freeze_shadow_o),
  .core_rst_o      (core_rst_o),
  .irq_o           (irq_o),
  .host_vld_o      (host_vld_o),
  .host_code_o     (host_code_o)
);

// File: tb/lockstep_monitor_tb_top.sv
`timescale 1ns/1ps
module lockstep_monitor_tb_top;
  localparam int VEC_W  = 16;
  localparam int CODE_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mon_en_i, err_clr_i, shadow_req_i, shadow_we_i, host_ack_i;
  logic [1:0]        lag_cfg_i, action_cfg_i;
  logic [VEC_W-1:0]  main_vec_i, shadow_vec_i;
  logic              shadow_req_o, freeze_main_o, freeze_shadow_o, core_rst_o, irq_o, host_vld_o;
  logic [1:0]        err_o;
  logic [CODE_W-1:0] host_code_o;

  always #10 clk = ~clk;

  lockstep_monitor #(.VEC_W(VEC_W), .MAX_LAG(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en_i(mon_en_i), .err_clr_i(err_clr_i),
    .lag_cfg_i(lag_cfg_i), .action_cfg_i(action_cfg_i),
    .main_vec_i(main_vec_i), .shadow_vec_i(shadow_vec_i),
    .shadow_req_i(shadow_req_i), .shadow_we_i(shadow_we_i), .host_ack_i(host_ack_i),
    .shadow_req_o(shadow_req_o), .err_o(err_o), .freeze_main_o(freeze_main_o),
    .freeze_shadow_o(freeze_shadow_o), .core_rst_o(core_rst_o), .irq_o(irq_o),
    .host_vld_o(host_vld_o), .host_code_o(host_code_o)
  );

  typedef struct {
    logic [1:0] err;
    logic       irq;
    logic       crst;
    int         req;
  } exp_t;

  exp_t             exp_q[$];
  logic [VEC_W-1:0] hist[$];
  int               n_chk = 0;
  int               n_fail = 0;
  bit               done = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        // R11: only the two legal codes may appear
        chk(err_o == 2'b01 || err_o == 2'b10, 11, "err code legal", {30'd0, err_o}, 32'h1);
        n_chk++;
        if (err_o !== e.err || irq_o !== e.irq || core_rst_o !== e.crst ||
            freeze_main_o !== (e.err == 2'b10) || freeze_shadow_o !== (e.err == 2'b10)) begin
          n_fail++;
          $display("FAIL R%0d err=%b irq=%b rst=%b frz=%b%b expected err=%b irq=%b rst=%b",
                   e.req, err_o, irq_o, core_rst_o, freeze_main_o, freeze_shadow_o,
                   e.err, e.irq, e.crst);
        end
      end
    end
  end

  task automatic step(input logic [VEC_W-1:0] m, input logic [VEC_W-1:0] s,
                      input logic [1:0] e_err, input logic e_irq, input logic e_rst,
                      input int req);
    exp_t e;
    @(negedge clk);
    main_vec_i   = m;
    shadow_vec_i = s;
    e.err = e_err; e.irq = e_irq; e.crst = e_rst; e.req = req;
    exp_q.push_back(e);
    @(posedge clk);
    #3;
  endtask

  // matching stream; the first lag entries after a flush carry junk (R5)
  task automatic run_clean(input int n, input int lag, input int req);
    for (int i = 0; i < n; i++) begin
      logic [VEC_W-1:0] m, s;
      int tag;
      m = VEC_W'($urandom);
      if (hist.size() >= lag) begin
        s   = hist[hist.size() - lag];
        tag = req;
      end else begin
        s   = ~m ^ 16'h5A5A;
        tag = 5;
      end
      hist.push_back(m);
      step(m, s, 2'b01, 1'b0, 1'b0, tag);
    end
  endtask

  task automatic inject(input int lag, input int bitpos, input logic e_irq,
                        input logic e_rst, input int req);
    logic [VEC_W-1:0] m, s;
    m = VEC_W'($urandom);
    s = hist[hist.size() - lag] ^ (VEC_W'(1) << bitpos);
    hist.push_back(m);
    step(m, s, 2'b10, e_irq, e_rst, req);
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(16'h1234, 16'hFFFF, 2'b01, 1'b0, 1'b0, req);
  endtask

  task automatic do_clear();
    err_clr_i = 1'b1;
    // R4: junk shadow data during the clear cycle must not raise a fault
    step(16'h0F0F, 16'hF0F0, 2'b01, 1'b0, 1'b0, 4);
    err_clr_i = 1'b0;
    hist.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mon_en_i = 1'b0; err_clr_i = 1'b0; lag_cfg_i = 2'd1;
    action_cfg_i = 2'd1; main_vec_i = '0; shadow_vec_i = '0;
    shadow_req_i = 1'b0; shadow_we_i = 1'b0; host_ack_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(err_o == 2'b01, 1, "err after reset", {30'd0, err_o}, 32'h1);
    chk(!freeze_main_o && !freeze_shadow_o && !irq_o && !core_rst_o && !host_vld_o,
        1, "actions idle", {27'd0, freeze_main_o, freeze_shadow_o, irq_o, core_rst_o, host_vld_o}, 32'h0);
    chk(host_code_o == '0, 1, "host code", {28'd0, host_code_o}, 32'h0);

    idle(2, 10);
    mon_en_i = 1'b1;
    hist.delete();
    run_clean(12, 1, 2);                 // R2 lag 1
    inject(1, 3, 1'b1, 1'b0, 3);         // R3 + R7 interrupt action
    action_cfg_i = 2'd2;                 // R12: later change has no effect
    for (int i = 0; i < 3; i++) step(16'h0, 16'h1, 2'b10, 1'b1, 1'b0, 12);
    do_clear();                          // R4 clear, irq drops

    run_clean(6, 1, 2);
    // R10: lag request while supervising is ignored, even with a mismatch on top
    lag_cfg_i = 2'd2;
    run_clean(6, 1, 10);
    inject(1, 5, 1'b0, 1'b0, 8);         // R8 host action
    chk(host_vld_o == 1'b1, 8, "host valid pulse", {31'd0, host_vld_o}, 32'h1);
    chk(host_code_o == 4'd5, 8, "host code", {28'd0, host_code_o}, 32'h5);
    step(16'h0, 16'h0, 2'b10, 1'b0, 1'b0, 8);
    chk(host_vld_o == 1'b0, 8, "host valid one cycle", {31'd0, host_vld_o}, 32'h0);
    chk(host_code_o == 4'd5, 8, "host code held", {28'd0, host_code_o}, 32'h5);
    host_ack_i = 1'b1;
    step(16'h0, 16'h0, 2'b10, 1'b0, 1'b0, 8);
    host_ack_i = 1'b0;
    chk(host_code_o == 4'd0, 8, "host code after ack", {28'd0, host_code_o}, 32'h0);

    do_clear();
    mon_en_i = 1'b0;
    idle(2, 10);                         // lag 2 taken while idle
    action_cfg_i = 2'd0;
    mon_en_i = 1'b1;
    hist.delete();
    run_clean(8, 2, 2);                  // R2 lag 2, first two junk (R5)
    inject(2, 9, 1'b0, 1'b1, 6);         // R6 reset action

    do_clear();
    mon_en_i = 1'b0;
    lag_cfg_i = 2'd3;                    // R10 saturates to 2
    idle(2, 10);
    action_cfg_i = 2'd3;
    mon_en_i = 1'b1;
    hist.delete();
    run_clean(6, 2, 10);
    inject(2, 0, 1'b0, 1'b1, 6);         // R6 action 3 behaves as reset

    do_clear();
    mon_en_i = 1'b0;
    lag_cfg_i = 2'd0;                    // R10 zero means one
    idle(2, 10);
    mon_en_i = 1'b1;
    hist.delete();
    run_clean(6, 1, 10);
    inject(1, 15, 1'b0, 1'b1, 6);

    // R9 shadow writes dropped, reads passed
    shadow_req_i = 1'b1; shadow_we_i = 1'b1;
    #1;
    chk(shadow_req_o == 1'b0, 9, "write blocked", {31'd0, shadow_req_o}, 32'h0);
    shadow_we_i = 1'b0;
    #1;
    chk(shadow_req_o == 1'b1, 9, "read passed", {31'd0, shadow_req_o}, 32'h1);
    shadow_req_i = 1'b0;

    repeat (2) @(posedge clk);
    #3;
    chk(exp_q.size() == 0, 2, "scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule